// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write a 16-bit asynchronous static RAM with an 18-bit word address. The host hands over one request at a time: an address, write data, a two-bit byte-lane mask and a read/write flag. The controller turns that request into a correctly timed pin sequence for the memory. Every memory timing limit is a parameter in nanoseconds. Each limit is rounded up to a whole number of host clock cycles, so the same RTL serves any speed grade and any clock period.

The memory side drives a pair of chip selects of opposite polarity (one active low, one active high), two active-low byte-lane controls, an active-low write strobe, an active-low output enable and the address. The data bus leaves the block as separate output, drive-enable and input vectors, ready for a bidirectional pad. All memory-side outputs come straight from flops.

The request interface is valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The controller takes a copy of the request fields on that edge, so the host may change them afterwards. `req_ready` stays low while an access is in flight. That is the only back-pressure. Completion is a one-cycle `rsp_valid` pulse with no ready of its own: the host must take `rsp_rdata` in that cycle, and it stays unchanged until the next read completes.

Top module: `sram_bridge`

## Requirements
- R1: During reset and after it, until a request is accepted, every memory control is inactive: `mem_cs_n`=1, `mem_cs`=0, `mem_lane_n`=2'b11, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. In the same period `req_ready`=1 and `rsp_valid`=0. Whenever the chip is deselected, the lane controls, strobe and output enable stay high.
- R2: A request is taken on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` is low from that edge until the cycle after the response. Each accepted request yields exactly one one-cycle `rsp_valid` pulse.
- R3: A read holds `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for RD_CYC cycles. RD_CYC is the largest of the rounded-up read cycle time, address access time and output-enable access time (6 at the defaults). `rsp_valid` rises in the cycle after the last access cycle.
- R4: Read data is sampled on the clock edge that ends the last access cycle. In `rsp_rdata`, a lane whose mask bit is 0 reads as zero. Mask bit 0 covers data bits 7:0 and bit 1 covers bits 15:8.
- R5: A write drives `mem_dq_o` with the write data and holds `mem_oe_n`=1 throughout. `mem_we_n` is low for WE_CYC consecutive cycles, the largest of the rounded-up strobe width, address-to-strobe-rise setup and data setup (5 at the defaults). It is followed by REC_CYC recovery cycles (the write cycle time minus WE_CYC, at least 1) in which the strobe is high while the selects, address and data are held.
- R6: During an access, `mem_lane_n[i]` is the inverse of request mask bit i, with `mem_lane_n[0]` gating bits 7:0. A write changes only the enabled lanes. A mask of 2'b00 leaves both lane controls high, so memory contents are unchanged.
- R7: `mem_addr` equals the accepted address from the first active cycle until the chip is deselected, even if `req_addr` changes meanwhile.
- R8: The first write after a read is preceded by TURN_CYC cycles (the rounded-up output turn-off time, at least 1; 2 at the defaults) in which all controls are inactive and the bus is not driven. A write that follows a write, or any read, starts at once.
- R9: The controller never drives the data bus while `mem_oe_n` is low, and `mem_we_n` and `mem_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request may transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_lane_n | output | 2 | Active-low byte-lane controls |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The assertions assume that the host drives `req_valid` and the request fields cleanly relative to the clock, and that the memory returns read data within the rounded-up access time. They also assume nothing else drives the bus while `mem_dq_oe` is high. The stimulus offers a request only while `req_ready` is high and scrambles `req_addr` and `req_wdata` after acceptance, so the copy taken at acceptance is what gets checked. The memory model answers reads from its contents, sampled mid-cycle with zero delay. Addresses come from a small pool that includes both ends of the address range, so reads often hit locations written earlier with mixed lane masks.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_READ,
    PH_STROBE,
    PH_RECOVER,
    PH_DONE
  } phase_t;

  // round a nanosecond limit up to whole clock periods given in picoseconds
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_fsm.sv
module sram_bridge_fsm
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned WE_CYC   = 5,
  parameter int unsigned REC_CYC  = 1,
  parameter int unsigned TURN_CYC = 2,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              capture,
  output phase_t            phase_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdata_d,
  output logic [LANES-1:0]  be_d,
  output logic [LANES-1:0]  be_q
);

  phase_t            phase_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              turn_q, turn_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WE   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC  = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

  logic cnt_zero;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    turn_d  = turn_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    be_d    = be_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          addr_d  = req_addr;
          wdata_d = req_wdata;
          be_d    = req_be;
          if (!req_write) begin
            phase_d = PH_READ;
            cnt_d   = LD_RD;
          end else if (turn_q) begin
            phase_d = PH_TURN;
            cnt_d   = LD_TURN;
          end else begin
            phase_d = PH_STROBE;
            cnt_d   = LD_WE;
          end
        end
      end
      PH_TURN: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = LD_WE;
        end
      end
      PH_READ: begin
        if (cnt_zero) begin
          phase_d = PH_DONE;
          turn_d  = 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d = PH_RECOVER;
          cnt_d   = LD_REC;
        end
      end
      PH_RECOVER: begin
        if (cnt_zero) begin
          phase_d = PH_DONE;
          turn_d  = 1'b0;
        end
      end
      PH_DONE:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      turn_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      turn_q  <= turn_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign rsp_valid = (phase_q == PH_DONE);
  assign capture   = (phase_q == PH_READ) && cnt_zero;

endmodule

// File: rtl/sram_bridge_pins.sv
module sram_bridge_pins
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [LANES-1:0]  be_d,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic [LANES-1:0]  mem_lane_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  logic active, reading, strobing, driving;

  // decode of the phase the controller enters on the next edge
  always_comb begin
    reading  = (phase_d == PH_READ);
    strobing = (phase_d == PH_STROBE);
    driving  = strobing || (phase_d == PH_RECOVER);
    active   = reading || driving;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_addr  <= addr_d;
      mem_cs_n  <= !active;
      mem_cs    <= active;
      mem_we_n  <= !strobing;
      mem_oe_n  <= !reading;
      mem_dq_oe <= driving;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_lane_n[g]                 <= 1'b1;
        mem_dq_o[g*LANE_W +: LANE_W]  <= '0;
      end else begin
        mem_lane_n[g]                 <= !(active && be_d[g]);
        mem_dq_o[g*LANE_W +: LANE_W]  <= wdata_d[g*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/sram_bridge_rcap.sv
module sram_bridge_rcap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  be_q,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rsp_rdata[g*LANE_W +: LANE_W] <= be_q[g] ? mem_dq_i[g*LANE_W +: LANE_W]
                                                 : '0;
      end
    end
  end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_OE_NS  = 30,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_WP_NS  = 45,
  parameter int unsigned T_AW_NS  = 50,
  parameter int unsigned T_DS_NS  = 25,
  parameter int unsigned T_OFF_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned RD_CYC   = max2(max2(ns_to_cycles(T_RC_NS, CLK_PS),
                                               ns_to_cycles(T_AA_NS, CLK_PS)),
                                          max2(ns_to_cycles(T_OE_NS, CLK_PS), 1));
  localparam int unsigned WE_CYC   = max2(max2(ns_to_cycles(T_WP_NS, CLK_PS),
                                               ns_to_cycles(T_AW_NS, CLK_PS)),
                                          max2(ns_to_cycles(T_DS_NS, CLK_PS), 1));
  localparam int unsigned WC_CYC   = ns_to_cycles(T_WC_NS, CLK_PS);
  localparam int unsigned REC_CYC  = (WC_CYC > WE_CYC + 1) ? WC_CYC - WE_CYC : 1;
  localparam int unsigned TURN_CYC = max2(ns_to_cycles(T_OFF_NS, CLK_PS), 1);
  localparam int unsigned CNT_MAX  = max2(max2(RD_CYC, WE_CYC), max2(REC_CYC, TURN_CYC));
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  phase_t            phase_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  be_d, be_q;
  logic              capture;

  sram_bridge_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC),
    .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .capture(capture),
    .phase_d(phase_d), .addr_d(addr_d), .wdata_d(wdata_d),
    .be_d(be_d), .be_q(be_q)
  );

  sram_bridge_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) pins_i (
    .clk(clk), .rst_n(rst_n),
    .phase_d(phase_d), .addr_d(addr_d), .wdata_d(wdata_d), .be_d(be_d),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_lane_n(mem_lane_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
  );

  sram_bridge_rcap #(
    .DATA_W(DATA_W), .LANES(LANES)
  ) rcap_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .be_q(be_q),
    .mem_dq_i(mem_dq_i), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_CYC = 6,
  parameter int unsigned WE_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic [LANES-1:0]  mem_lane_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? '0 : ((we_run == '1) ? we_run : we_run + 1'b1);
      oe_run <= mem_oe_n ? '0 : ((oe_run == '1) ? oe_run : oe_run + 1'b1);
    end
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= 16'(WE_CYC)));

  // R3
  read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run >= 16'(RD_CYC)));

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n || req_ready) |-> (mem_cs_n && (&mem_lane_n) && mem_we_n && mem_oe_n));

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_lane_n(mem_lane_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_bridge_tb_top.sv
`timescale 1ns/1ps
module sram_bridge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = CLK_PERIOD * 1000;

  function automatic int cyc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected cycle counts from the requirement text
  localparam int E_RD   = imax(imax(cyc(55), cyc(55)), cyc(30));
  localparam int E_WE   = imax(imax(cyc(45), cyc(50)), cyc(25));
  localparam int E_REC  = imax(1, cyc(55) - E_WE);
  localparam int E_TURN = imax(1, cyc(20));

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_lane_n(mem_lane_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit last_rd = 1'b0;

  logic [15:0] marr [logic [17:0]];   // memory model contents
  logic [15:0] shadow [logic [17:0]]; // expected contents
  logic [17:0] pool [16];

  function automatic logic [15:0] lmask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: acts mid-cycle on the pin state of the current cycle
  always @(negedge clk) begin
    logic [15:0] w, m;
    mem_dq_i <= 'z;
    if (!mem_cs_n && mem_cs) begin
      w = marr.exists(mem_addr) ? marr[mem_addr] : 16'h0000;
      m = {{8{!mem_lane_n[1]}}, {8{!mem_lane_n[0]}}};
      if (!mem_we_n && mem_dq_oe) begin
        marr[mem_addr] = (w & ~m) | (mem_dq_o & m);
      end else if (mem_we_n && !mem_oe_n) begin
        mem_dq_i <= {m[15] ? w[15:8] : 8'hzz, m[0] ? w[7:0] : 8'hzz};
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_op(input bit wr, input logic [17:0] a,
                       input logic [15:0] d, input logic [1:0] be);
    int k = 1;
    int act_cyc = 0, pre_cyc = 0, we_low = 0, bad = 0, busy = 0;
    logic [15:0] old, expd;
    bit need_turn;
    need_turn = wr && last_rd;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R2 ready before request", {req_ready, rsp_valid}, 2'b10);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 18'($urandom); req_wdata = 16'($urandom);
    while (!rsp_valid && k < 64) begin
      if (req_ready) busy++;
      if (!(!mem_cs_n && mem_cs)) begin
        if (act_cyc == 0) pre_cyc++;
        if (!(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe && mem_lane_n == 2'b11)) bad++;
      end else begin
        act_cyc++;
        if (mem_addr !== a) bad++;
        if (mem_lane_n !== ~be) bad++;
        if (wr) begin
          if (!mem_oe_n || !mem_dq_oe || mem_dq_o !== d) bad++;
          if (!mem_we_n) we_low++;
          if ((!mem_we_n) != (act_cyc <= E_WE)) bad++;
        end else begin
          if (mem_oe_n || !mem_we_n || mem_dq_oe) bad++;
        end
      end
      @(negedge clk);
      k++;
    end
    chk(busy == 0, "R2 ready low while busy", busy, 0);
    chk(bad == 0, wr ? "R5/R6/R7 write pin sequence" : "R3/R6/R7 read pin sequence", bad, 0);
    if (wr) begin
      chk(k == (need_turn ? E_TURN : 0) + E_WE + E_REC + 1, "R5 write response cycle",
          k, (need_turn ? E_TURN : 0) + E_WE + E_REC + 1);
      chk(we_low == E_WE, "R5 strobe width", we_low, E_WE);
      chk(act_cyc == E_WE + E_REC, "R5 write recovery", act_cyc, E_WE + E_REC);
      chk(pre_cyc == (need_turn ? E_TURN : 0), "R8 turnaround cycles",
          pre_cyc, need_turn ? E_TURN : 0);
      old = shadow.exists(a) ? shadow[a] : 16'h0000;
      shadow[a] = (old & ~lmask(be)) | (d & lmask(be));
    end else begin
      chk(k == E_RD + 1, "R3 read response cycle", k, E_RD + 1);
      chk(act_cyc == E_RD && pre_cyc == 0, "R3 read window", act_cyc, E_RD);
      expd = (shadow.exists(a) ? shadow[a] : 16'h0000) & lmask(be);
      chk(rsp_rdata === expd, "R4 read data", rsp_rdata, expd);
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R2 single response pulse", {rsp_valid, req_ready}, 2'b01);
    last_rd = !wr;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    pool[0] = 18'h00000;
    pool[1] = 18'h3FFFF;
    for (int i = 2; i < 16; i++) pool[i] = 18'($urandom);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && !mem_cs && mem_lane_n == 2'b11 && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 controls inactive in reset", {mem_cs_n, mem_cs, mem_lane_n, mem_we_n, mem_oe_n, mem_dq_oe}, 7'b1011110);
    chk(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 idle after reset", {req_ready, rsp_valid}, 2'b10);

    // directed corners
    do_op(1, pool[0], 16'hFFFF, 2'b11);     // write after nothing: no turn
    do_op(0, pool[0], 16'h0000, 2'b11);     // read back full word
    do_op(1, pool[0], 16'h1234, 2'b01);     // R8 write after read, lane 0 only
    do_op(1, pool[0], 16'hABCD, 2'b00);     // R6 mask 00 changes nothing
    do_op(0, pool[0], 16'h0000, 2'b11);     // expect FF34
    do_op(0, pool[0], 16'h0000, 2'b10);     // R4 lane 1 only
    do_op(0, pool[0], 16'h0000, 2'b00);     // R4 no lanes read as zero
    do_op(1, pool[1], 16'h5A5A, 2'b10);     // top address, upper lane
    do_op(1, pool[1], 16'hC3C3, 2'b01);     // write after write
    do_op(0, pool[1], 16'h0000, 2'b11);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      do_op(1'($urandom), pool[$urandom % 16], 16'($urandom), 2'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule